// File: doc/BRIEF.md
# Power Island Gating Controller

This controller owns one switchable power island in an on-chip network. The island contains a target IP block together with the slice of fabric that serves it. Software turns the island off by raising a power-down request and waiting for the acknowledge. Before it acknowledges, the controller asks every initiator that can reach the island to stop sending to it. Once all of them have agreed, it waits until every transaction already under way has completed. Only then does it clamp the island's outputs and remove power.

While the island is dark, a new request aimed at it can bring it back by itself when auto-wake is enabled. The request is held at the island boundary while power returns, and it is delivered normally once the island is up, so the requester sees no error. If auto-wake is disabled, or power-good does not return within a programmed number of cycles, the request completes at once with an error. The software power-down handshake uses four wires in total: power-down request and acknowledge, auto-wake enable, and auto-wake request.

Top module: `pwr_island_ctl`

## Requirements
- R1: After reset the island is powered and usable: `pd_ack`=0, `iso_en`=0, `pwr_en`=1, `wake_req`=0, `blk_req` all zero.
- R2: One cycle after `pd_req` is sampled high in the running state, every bit of `blk_req` is 1. Requests are still forwarded until every bit of `blk_vote` is 1 in the same cycle.
- R3: Once all votes are in, new requests are stalled (`req_rdy`=0) and isolation stays off while the drain is in progress.
- R4: Going down, `iso_en` rises one cycle before `pwr_en` falls. `pd_ack` is 1 exactly in the cycles where the island is off (`pwr_en`=0, `iso_en`=1).
- R5: If `pd_req` drops while votes are being collected or during the drain, the controller returns to the running state the next cycle: `blk_req` is cleared and no acknowledge is given.
- R6: When the island is off, `wake_en`=1 and `req_vld`=1, the next cycle shows `wake_req`=1, `pwr_en`=1 and `iso_en`=1. The request is stalled (`req_rdy`=0).
- R7: Isolation is released only in the cycle after `pwr_good` is seen high during a wake. The held request is then accepted with `req_err`=0 and `fwd_vld`=1.
- R8: When the island is off and `wake_en`=0, a request is accepted in the same cycle with `req_err`=1. The island stays off (`pwr_en`=0, `pd_ack`=1).
- R9: The cycle counter starts at 0 on the first wake cycle. If it reaches `wake_tmo` while `pwr_good` is low, a pending request completes with `req_err`=1 in that cycle, and the next cycle the island is off again with `wake_req`=0.
- R10: Dropping `pd_req` while the island is off starts a wake with no request present. Power-good then brings the island back to running, with `pd_ack`=0.
- R11: An outstanding counter rises on each forwarded request and falls on each `rsp_done`. Isolation is not asserted until the counter is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_req | input | 1 | Software power-down request (level) |
| pd_ack | output | 1 | Power-down acknowledge, high while the island is off |
| wake_en | input | 1 | Auto-wake enable |
| wake_req | output | 1 | Auto-wake request, high while power is being restored |
| blk_req | output | NUM_INIT | Per-initiator request to block traffic toward the island |
| blk_vote | input | NUM_INIT | Per-initiator vote that its traffic is blocked |
| req_vld | input | 1 | Request toward the island is valid |
| req_rdy | output | 1 | Request is taken this cycle (forwarded or errored) |
| req_err | output | 1 | With `req_rdy`, the request completes with an error |
| fwd_vld | output | 1 | Request is passed into the island this cycle |
| rsp_done | input | 1 | Island completed one forwarded transaction |
| iso_en | output | 1 | Output isolation clamp enable |
| pwr_en | output | 1 | Power switch enable |
| pwr_good | input | 1 | Island supply is stable |
| wake_tmo | input | TMO_W | Wake timeout, in cycles |

## Verification
The request outcomes (`req_rdy`, `req_err`, `fwd_vld`) are combinational on the current state and inputs, so they are due in the same cycle the request is presented. Every state-decoded output (`blk_req`, `iso_en`, `pwr_en`, `pd_ack`, `wake_req`) changes one cycle after the input that causes the transition is sampled. The drain exit adds one more cycle, because the counter register must first read zero. The bench drives inputs on the falling edge and samples outputs 1 ns later, counting these edges exactly. A scoreboard queue pairs each issued request with its expected outcome, error or delivery, and a monitor pops the queue on every handshake.

// File: rtl/pwr_island_ctl.sv
module pwr_island_ctl #(
  parameter int NUM_INIT = 3,
  parameter int CNT_W    = 4,
  parameter int TMO_W    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pd_req,
  output logic                pd_ack,
  input  logic                wake_en,
  output logic                wake_req,
  output logic [NUM_INIT-1:0] blk_req,
  input  logic [NUM_INIT-1:0] blk_vote,
  input  logic                req_vld,
  output logic                req_rdy,
  output logic                req_err,
  output logic                fwd_vld,
  input  logic                rsp_done,
  output logic                iso_en,
  output logic                pwr_en,
  input  logic                pwr_good,
  input  logic [TMO_W-1:0]    wake_tmo
);

  localparam logic [CNT_W-1:0] CNT_FULL = '1;

  typedef enum logic [2:0] {
    S_RUN, S_VOTE, S_DRAIN, S_CLAMP, S_DARK, S_WAKE
  } state_t;

  state_t           st, st_nx;
  logic [CNT_W-1:0] cnt;
  logic [TMO_W-1:0] tmr;
  logic             all_voted, tmo_hit, err_now;

  assign all_voted = &blk_vote;
  assign tmo_hit   = (st == S_WAKE) && (tmr == wake_tmo) && !pwr_good;

  assign fwd_vld  = req_vld && (st == S_RUN || st == S_VOTE);
  assign err_now  = req_vld && (((st == S_DARK) && !wake_en) || tmo_hit);
  assign req_rdy  = fwd_vld || err_now;
  assign req_err  = err_now;

  assign blk_req  = {NUM_INIT{st != S_RUN}};
  assign iso_en   = (st == S_CLAMP) || (st == S_DARK) || (st == S_WAKE);
  assign pwr_en   = (st != S_DARK);
  assign pd_ack   = (st == S_DARK);
  assign wake_req = (st == S_WAKE);

  always_comb begin
    st_nx = st;
    case (st)
      S_RUN:   if (pd_req) st_nx = S_VOTE;
      S_VOTE:  if (!pd_req) st_nx = S_RUN;
               else if (all_voted) st_nx = S_DRAIN;
      S_DRAIN: if (!pd_req) st_nx = S_RUN;
               else if (cnt == '0) st_nx = S_CLAMP;
      S_CLAMP: st_nx = S_DARK;
      S_DARK:  if ((req_vld && wake_en) || !pd_req) st_nx = S_WAKE;
      S_WAKE:  if (pwr_good) st_nx = S_RUN;
               else if (tmo_hit) st_nx = S_DARK;
      default: st_nx = S_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_RUN;
      cnt <= '0;
      tmr <= '0;
    end else begin
      st  <= st_nx;
      tmr <= (st == S_WAKE) ? tmr + 1'b1 : '0;
      case ({fwd_vld, rsp_done})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !(cnt == CNT_FULL && fwd_vld && !rsp_done)); // R11
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !(cnt == '0 && rsp_done && !fwd_vld)); // R11
  AST_CLAMP_AFTER_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DRAIN && st_nx == S_CLAMP) |-> (cnt == '0)); // R11
  AST_VOTES_BEFORE_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_VOTE && pd_req) |=> (st == S_DRAIN) == $past(all_voted)); // R2
  AST_ISO_BEFORE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_en) |-> $past(iso_en)); // R4
  AST_PG_BEFORE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(iso_en) |-> $past(pwr_good)); // R7
  AST_NO_FWD_CLAMPED: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_vld |-> !iso_en && pwr_en); // R7
  AST_WITHDRAW: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_VOTE || st == S_DRAIN) && !pd_req) |=> (st == S_RUN && !pd_ack)); // R5

endmodule

// File: tb/pwr_island_ctl_tb_top.sv
module pwr_island_ctl_tb_top;
  localparam int NI = 3;
  localparam int TW = 8;

  logic clk = 0, rst_n = 0;
  logic pd_req = 0, wake_en = 1, req_vld = 0, rsp_done = 0, pwr_good = 1;
  logic [NI-1:0] blk_vote = '0;
  logic [TW-1:0] wake_tmo = 8'd10;
  logic pd_ack, wake_req, req_rdy, req_err, fwd_vld, iso_en, pwr_en;
  logic [NI-1:0] blk_req;

  int n_chk = 0, n_fail = 0;
  bit exp_q[$];

  always #2 clk = ~clk;

  pwr_island_ctl #(.NUM_INIT(NI), .CNT_W(4), .TMO_W(TW)) dut_i (
    .clk(clk), .rst_n(rst_n), .pd_req(pd_req), .pd_ack(pd_ack),
    .wake_en(wake_en), .wake_req(wake_req), .blk_req(blk_req), .blk_vote(blk_vote),
    .req_vld(req_vld), .req_rdy(req_rdy), .req_err(req_err), .fwd_vld(fwd_vld),
    .rsp_done(rsp_done), .iso_en(iso_en), .pwr_en(pwr_en), .pwr_good(pwr_good),
    .wake_tmo(wake_tmo));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic issue(bit exp_err);
    @(negedge clk);
    exp_q.push_back(exp_err);
    req_vld = 1;
    #1;
    while (!req_rdy) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    req_vld = 0;
  endtask

  always @(negedge clk) begin
    #1;
    if (req_vld && req_rdy) begin
      if (exp_q.size() == 0) begin
        chk("scoreboard unexpected handshake", 1, 0);
      end else begin
        bit e;
        e = exp_q.pop_front();
        chk("scoreboard req_err (R7 R8 R9)", req_err, e);
        chk("scoreboard fwd_vld (R2 R7)", fwd_vld, !e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1 pd_ack", pd_ack, 0);
    chk("R1 iso_en", iso_en, 0);
    chk("R1 pwr_en", pwr_en, 1);
    chk("R1 wake_req", wake_req, 0);
    chk("R1 blk_req", blk_req, 0);

    issue(0);
    issue(0);

    // power down with a partial vote first
    pd_req = 1; blk_vote = 3'b011;
    @(negedge clk); #1;
    chk("R2 blk_req", blk_req, 3'b111);
    chk("R2 pd_ack", pd_ack, 0);
    issue(0);                       // R2: still forwarded while votes incomplete
    blk_vote = 3'b111;
    @(negedge clk); req_vld = 1; #1;
    chk("R3 stalled in drain", req_rdy, 0);
    chk("R3 iso off in drain", iso_en, 0);
    @(negedge clk); req_vld = 0; rsp_done = 1;
    repeat (2) @(negedge clk);
    @(negedge clk); rsp_done = 0; #1;
    chk("R11 iso off until counter zero", iso_en, 0);
    @(negedge clk); #1;
    chk("R4 iso first", iso_en, 1);
    chk("R4 pwr still on", pwr_en, 1);
    chk("R4 no ack yet", pd_ack, 0);
    pwr_good = 0;
    @(negedge clk); #1;
    chk("R4 pwr off", pwr_en, 0);
    chk("R4 ack", pd_ack, 1);

    wake_en = 0;
    issue(1);
    #1;
    chk("R8 stays off", pwr_en, 0);
    chk("R8 ack held", pd_ack, 1);
    chk("R8 no wake", wake_req, 0);

    wake_en = 1;
    fork issue(0); join_none
    @(negedge clk); #1;
    chk("R6 stalled while off", req_rdy, 0);
    @(negedge clk); #1;
    chk("R6 wake_req", wake_req, 1);
    chk("R6 pwr_en", pwr_en, 1);
    chk("R6 iso held", iso_en, 1);
    chk("R6 stalled in wake", req_rdy, 0);
    @(negedge clk);
    @(negedge clk); pwr_good = 1;
    @(negedge clk); pd_req = 0; #1;
    chk("R7 iso released", iso_en, 0);
    chk("R7 delivered", req_rdy, 1);
    chk("R7 no error", req_err, 0);
    @(negedge clk); rsp_done = 1;
    @(negedge clk); rsp_done = 0;

    // withdraw during vote
    blk_vote = 3'b000; pd_req = 1;
    @(negedge clk); pd_req = 0; #1;
    chk("R5 blocking in vote", blk_req, 3'b111);
    @(negedge clk); #1;
    chk("R5 unblocked", blk_req, 0);
    chk("R5 no ack", pd_ack, 0);

    // withdraw during drain
    issue(0);
    blk_vote = 3'b111; pd_req = 1;
    @(negedge clk);
    @(negedge clk); pd_req = 0; #1;
    chk("R5 in drain", blk_req, 3'b111);
    @(negedge clk); #1;
    chk("R5 drain unblocked", blk_req, 0);
    chk("R5 drain no ack", pd_ack, 0);
    chk("R5 drain iso off", iso_en, 0);
    @(negedge clk); rsp_done = 1;
    @(negedge clk); rsp_done = 0;

    // down again, then timed-out wake
    pd_req = 1;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk); pwr_good = 0;
    @(negedge clk); wake_tmo = 8'd3; #1;
    chk("R4 ack second down", pd_ack, 1);
    fork issue(1); join_none
    @(negedge clk); #1;
    chk("R9 stalled off", req_rdy, 0);
    @(negedge clk); #1;
    chk("R9 tmr0 stalled", req_rdy, 0);
    @(negedge clk);
    @(negedge clk); #1;
    chk("R9 before expiry", req_rdy, 0);
    chk("R9 waking", wake_req, 1);
    @(negedge clk); #1;
    chk("R9 expiry rdy", req_rdy, 1);
    chk("R9 expiry err", req_err, 1);
    @(negedge clk); #1;
    chk("R9 back off", pwr_en, 0);
    chk("R9 wake dropped", wake_req, 0);
    chk("R9 ack", pd_ack, 1);

    // software wake
    @(negedge clk); pd_req = 0;
    @(negedge clk); pwr_good = 1; #1;
    chk("R10 wake_req", wake_req, 1);
    chk("R10 pwr_en", pwr_en, 1);
    chk("R10 iso held", iso_en, 1);
    @(negedge clk); #1;
    chk("R10 iso released", iso_en, 0);
    chk("R10 ack cleared", pd_ack, 0);
    chk("R10 blk cleared", blk_req, 0);

    repeat (2) @(negedge clk);
    chk("scoreboard drained", exp_q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule